// File: doc/BRIEF.md
# Register-Mapped Serial Peripheral Interface Controller

This block is an 8-bit SPI controller that sits on a simple synchronous register port. Software picks master or slave operation, clock polarity and clock phase in a control register. A baud register sets the serial clock rate from the bus clock. The rate is the product of a small linear prescaler and a power-of-two stage. A status register reports whether the transmit holding register can take a byte and whether a received byte is waiting. A single data register is used both to queue the outgoing byte and to read the last received one.

In master mode, writing a byte starts a frame. The block drives the serial clock and the outgoing data line, samples the incoming line, and raises receive-full after the eighth bit. In slave mode, the queued byte waits in the shifter. Bits move only while the external active-low select is low, timed by the synchronized external clock. The slave output is released whenever select is high.

Top module: `spi_reg_core`

## Requirements
- R1: After reset, the control register (address 0) and the baud register (address 1) read 0x00. The status register (address 2) reads 0x01: bit 0 is transmit-empty and is 1, bit 1 is receive-full and is 0.
- R2: Control bit 6 is enable, bit 4 is master (1) or slave (0), bit 3 is clock polarity and bit 2 is clock phase. Baud bits 6:4 hold the prescaler and bits 3:0 hold the power-of-two field. Written fields read back unchanged, and every other bit reads 0.
- R3: While enable is 0, a byte written to the data register (address 3) is held, no serial clock edge occurs, and transmit-empty stays 0.
- R4: In master mode, each half period of the serial clock lasts (prescaler+1) x 2^field bus cycles. The full period is therefore (prescaler+1) x 2^(field+1).
- R5: Power-of-two field values above 8 give the same rate as 8.
- R6: A master frame is 8 bits, MSB first. With phase 0, the incoming line is sampled on each leading clock edge. With phase 1, it is sampled on each trailing edge. The received byte is read back from the data register.
- R7: An accepted data write clears transmit-empty. Transmit-empty is set again when the byte moves into the shifter. A data write made while transmit-empty is 0 is ignored.
- R8: Receive-full is set when the eighth bit has been shifted in. Reading the data register returns that byte and clears receive-full.
- R9: In slave mode, the output-enable of the slave data output is 1 only while select is low. Clock edges seen while select is high shift nothing.
- R10: A slave frame, in any of the four modes, receives the byte sent by the external master and returns the queued byte, both MSB first.
- R11: Whenever no master frame is in progress, the serial clock output rests at the clock polarity level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears receive-full on a data read) |
| reg_addr | input | 2 | Register select: 0 control, 1 baud, 2 status, 3 data |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| sclk_o | output | 1 | Serial clock driven in master mode |
| sclk_oe | output | 1 | Serial clock output enable |
| sclk_i | input | 1 | External serial clock in slave mode |
| mosi_o | output | 1 | Master data output |
| mosi_oe | output | 1 | Master data output enable |
| mosi_i | input | 1 | Slave data input |
| miso_o | output | 1 | Slave data output |
| miso_oe | output | 1 | Slave data output enable |
| miso_i | input | 1 | Master data input |
| ss_n_i | input | 1 | Active-low slave select |

## Verification
Several rules hold on every cycle and are checked by the assertions:
- the slave output is released while select is high;
- the idle serial clock rests at the polarity level;
- clearing enable ends any master frame;
- an accepted data write drops transmit-empty;
- receive-full follows frame completion and data reads.

Other behaviour needs whole scenarios and is covered by the bench:
- bit order and the sampling edge in each mode;
- the exact half-period for each baud setting, including saturation of the power-of-two field;
- the rule that a second write is ignored;
- slave frames with clock activity while select is high.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;
   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_BAUD = 2'd1,
      REG_STAT = 2'd2,
      REG_DATA = 2'd3
   } reg_sel_e;

   localparam int CTRL_EN_BIT   = 6;
   localparam int CTRL_MSTR_BIT = 4;
   localparam int CTRL_CPOL_BIT = 3;
   localparam int CTRL_CPHA_BIT = 2;
   localparam int BAUD_PRE_LSB  = 4;
   localparam int BAUD_POW_LSB  = 0;
   localparam int STAT_TXE_BIT  = 0;
   localparam int STAT_RXF_BIT  = 1;
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
   parameter int             W       = 1,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stage_q [STAGES];

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stage_q[0] <= RST_VAL;
               else        stage_q[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stage_q[i] <= RST_VAL;
               else        stage_q[i] <= stage_q[i-1];
         end
      end
   endgenerate

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
   parameter int PRE_W   = 3,
   parameter int POW_W   = 4,
   parameter int POW_MAX = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PRE_W-1:0] pre,
   input  logic [POW_W-1:0] pow,
   output logic             tick
);
   localparam int CNT_W = PRE_W + POW_MAX + 1;

   logic [POW_W-1:0] shamt;
   logic [CNT_W-1:0] half;
   logic [CNT_W-1:0] cnt_q;

   always_comb begin
      shamt = (pow > POW_W'(POW_MAX)) ? POW_W'(POW_MAX) : pow;
      half  = (CNT_W'(pre) + CNT_W'(1)) << shamt;
   end

   assign tick = run && (cnt_q == half - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)    cnt_q <= '0;
      else if (!run) cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else           cnt_q <= cnt_q + CNT_W'(1);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         load,
   input  logic [W-1:0] load_byte,
   input  logic         step,
   input  logic         cpha,
   input  logic         sin,
   output logic         sout,
   output logic [W-1:0] rx_byte,
   output logic         done,
   output logic         idle
);
   localparam int CNT_W = $clog2(2 * W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(2 * W - 1);

   logic [W-1:0]     tx_q, rx_q;
   logic [CNT_W-1:0] cnt_q;
   logic             lead, sample;

   assign lead   = ~cnt_q[0];
   assign sample = lead ^ cpha;
   assign sout   = tx_q[W-1];
   assign idle   = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q    <= '0;
         rx_q    <= '0;
         cnt_q   <= '0;
         rx_byte <= '0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (load) begin
            tx_q  <= load_byte;
            cnt_q <= '0;
         end else if (clr) begin
            cnt_q <= '0;
         end else if (step) begin
            if (sample)              rx_q <= {rx_q[W-2:0], sin};
            else if (cnt_q != '0)    tx_q <= {tx_q[W-2:0], 1'b0};
            if (cnt_q == LAST) begin
               cnt_q   <= '0;
               done    <= 1'b1;
               rx_byte <= sample ? {rx_q[W-2:0], sin} : rx_q;
            end else begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/spi_reg_core.sv
module spi_reg_core
   import spi_reg_pkg::*;
#(
   parameter int FRAME_W     = 8,
   parameter int PRE_W       = 3,
   parameter int POW_W       = 4,
   parameter int POW_MAX     = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         reg_wr,
   input  logic         reg_rd,
   input  logic [1:0]   reg_addr,
   input  logic [7:0]   reg_wdata,
   output logic [7:0]   reg_rdata,
   output logic         sclk_o,
   output logic         sclk_oe,
   input  logic         sclk_i,
   output logic         mosi_o,
   output logic         mosi_oe,
   input  logic         mosi_i,
   output logic         miso_o,
   output logic         miso_oe,
   input  logic         miso_i,
   input  logic         ss_n_i
);
   generate
      if (FRAME_W != 8) begin : g_bad_frame
         $error("spi_reg_core: FRAME_W must be 8");
      end
      if (BAUD_PRE_LSB + PRE_W > 7) begin : g_bad_pre
         $error("spi_reg_core: prescaler field overflows the baud register");
      end
      if (POW_W > BAUD_PRE_LSB || POW_MAX >= (1 << POW_W)) begin : g_bad_pow
         $error("spi_reg_core: power-of-two field does not fit");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("spi_reg_core: at least two synchronizer stages needed");
      end
   endgenerate

   reg_sel_e sel;
   assign sel = reg_sel_e'(reg_addr);

   logic               en_q, mstr_q, cpol_q, cpha_q;
   logic [PRE_W-1:0]   pre_q;
   logic [POW_W-1:0]   pow_q;
   logic [FRAME_W-1:0] txbuf_q, rxdata_q;
   logic               tx_empty_q, rx_full_q;
   logic               busy_q, lvl_q, sclk_d_q;

   logic               sclk_s, mosi_s, ss_n_s;
   logic               tick, eng_done, eng_idle, eng_sout;
   logic [FRAME_W-1:0] eng_rx;
   logic               wr_data, rd_data, slv_act;
   logic               m_step, sl_step, step, m_load, s_load, eng_clr;

   spi_in_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({sclk_i, mosi_i, ss_n_i}),
      .q     ({sclk_s, mosi_s, ss_n_s})
   );

   spi_baud_gen #(.PRE_W(PRE_W), .POW_W(POW_W), .POW_MAX(POW_MAX)) u_baud (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy_q),
      .pre   (pre_q),
      .pow   (pow_q),
      .tick  (tick)
   );

   assign wr_data = reg_wr && (sel == REG_DATA);
   assign rd_data = reg_rd && (sel == REG_DATA);
   assign slv_act = en_q & ~mstr_q;
   assign m_step  = busy_q & tick & ~eng_done;
   assign sl_step = slv_act & ~ss_n_s & (sclk_s ^ sclk_d_q);
   assign step    = mstr_q ? m_step : sl_step;
   assign m_load  = en_q & mstr_q & ~busy_q & ~tx_empty_q;
   assign s_load  = slv_act & ~tx_empty_q & eng_idle & ~sl_step;
   assign eng_clr = ~en_q | (~mstr_q & ss_n_s);

   spi_shift_engine #(.W(FRAME_W)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (eng_clr),
      .load      (m_load | s_load),
      .load_byte (txbuf_q),
      .step      (step),
      .cpha      (cpha_q),
      .sin       (mstr_q ? miso_i : mosi_s),
      .sout      (eng_sout),
      .rx_byte   (eng_rx),
      .done      (eng_done),
      .idle      (eng_idle)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mstr_q <= 1'b0;
         cpol_q <= 1'b0;
         cpha_q <= 1'b0;
         pre_q  <= '0;
         pow_q  <= '0;
      end else if (reg_wr) begin
         if (sel == REG_CTRL) begin
            en_q   <= reg_wdata[CTRL_EN_BIT];
            mstr_q <= reg_wdata[CTRL_MSTR_BIT];
            cpol_q <= reg_wdata[CTRL_CPOL_BIT];
            cpha_q <= reg_wdata[CTRL_CPHA_BIT];
         end
         if (sel == REG_BAUD) begin
            pre_q <= reg_wdata[BAUD_PRE_LSB +: PRE_W];
            pow_q <= reg_wdata[BAUD_POW_LSB +: POW_W];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txbuf_q    <= '0;
         tx_empty_q <= 1'b1;
         rx_full_q  <= 1'b0;
         rxdata_q   <= '0;
      end else begin
         if (m_load | s_load) begin
            tx_empty_q <= 1'b1;
         end else if (wr_data && tx_empty_q) begin
            tx_empty_q <= 1'b0;
            txbuf_q    <= reg_wdata;
         end
         if (eng_done) begin
            rx_full_q <= 1'b1;
            rxdata_q  <= eng_rx;
         end else if (rd_data) begin
            rx_full_q <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         lvl_q    <= 1'b0;
         sclk_d_q <= 1'b0;
      end else begin
         sclk_d_q <= sclk_s;
         if (~en_q | ~mstr_q) busy_q <= 1'b0;
         else if (m_load)     busy_q <= 1'b1;
         else if (eng_done)   busy_q <= 1'b0;
         if (~en_q | ~mstr_q | ~busy_q) lvl_q <= 1'b0;
         else if (m_step)               lvl_q <= ~lvl_q;
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (sel)
         REG_CTRL: begin
            reg_rdata[CTRL_EN_BIT]   = en_q;
            reg_rdata[CTRL_MSTR_BIT] = mstr_q;
            reg_rdata[CTRL_CPOL_BIT] = cpol_q;
            reg_rdata[CTRL_CPHA_BIT] = cpha_q;
         end
         REG_BAUD: begin
            reg_rdata[BAUD_PRE_LSB +: PRE_W] = pre_q;
            reg_rdata[BAUD_POW_LSB +: POW_W] = pow_q;
         end
         REG_STAT: begin
            reg_rdata[STAT_TXE_BIT] = tx_empty_q;
            reg_rdata[STAT_RXF_BIT] = rx_full_q;
         end
         default: reg_rdata = rxdata_q;
      endcase
   end

   assign sclk_o  = cpol_q ^ lvl_q;
   assign sclk_oe = en_q & mstr_q;
   assign mosi_o  = eng_sout;
   assign mosi_oe = en_q & mstr_q;
   assign miso_o  = eng_sout;
   assign miso_oe = slv_act & ~ss_n_i;
endmodule

// File: rtl/spi_reg_core_chk.sv
module spi_reg_core_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       reg_wr,
   input logic       reg_rd,
   input logic [1:0] reg_addr,
   input logic       ss_n_i,
   input logic       miso_oe,
   input logic       sclk_o,
   input logic       cpol_q,
   input logic       en_q,
   input logic       busy_q,
   input logic       tx_empty_q,
   input logic       rx_full_q,
   input logic       eng_done
);
   AST_MISO_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      ss_n_i |-> !miso_oe); // R9
   AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> (sclk_o == cpol_q)); // R11
   AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> !busy_q); // R3
   AST_TXE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 2'd3 && tx_empty_q) |=> !tx_empty_q); // R7
   AST_RXF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == 2'd3 && !eng_done) |=> !rx_full_q); // R8
   AST_RXF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      eng_done |=> rx_full_q); // R8
endmodule

bind spi_reg_core spi_reg_core_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_rd     (reg_rd),
   .reg_addr   (reg_addr),
   .ss_n_i     (ss_n_i),
   .miso_oe    (miso_oe),
   .sclk_o     (sclk_o),
   .cpol_q     (cpol_q),
   .en_q       (en_q),
   .busy_q     (busy_q),
   .tx_empty_q (tx_empty_q),
   .rx_full_q  (rx_full_q),
   .eng_done   (eng_done)
);

// File: tb/spi_reg_core_bench.sv
`timescale 1ns/1ps
module spi_reg_core_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr = 1'b0, reg_rd = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic [7:0] reg_wdata = 8'h00, reg_rdata;
   logic       sclk_o, sclk_oe, sclk_i = 1'b0;
   logic       mosi_o, mosi_oe, mosi_i = 1'b0;
   logic       miso_o, miso_oe, miso_i;
   logic       ss_n_i = 1'b1;

   int n_chk = 0, n_err = 0;
   int cyc = 0;
   bit finished = 1'b0;

   // bench-side slave model used while the block is master
   bit         m_on = 1'b0, m_cpha = 1'b0, m_prev = 1'b0;
   int         m_ecnt = 0, m_gap = 0, m_last = 0;
   logic [7:0] m_slv = 8'h00, m_cap = 8'h00;

   assign miso_i = m_slv[7];

   always #2 clk = ~clk;

   spi_reg_core u_spi_reg_core (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .sclk_o(sclk_o), .sclk_oe(sclk_oe), .sclk_i(sclk_i),
      .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_i),
      .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i), .ss_n_i(ss_n_i)
   );

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (m_on && sclk_o !== m_prev) begin
         bit leading;
         leading = (m_ecnt % 2 == 0);
         if ((leading && !m_cpha) || (!leading && m_cpha)) m_cap = {m_cap[6:0], mosi_o};
         else if (m_ecnt != 0) m_slv = {m_slv[6:0], 1'b0};
         if (m_ecnt == 1) m_gap = cyc - m_last;
         m_last = cyc;
         m_ecnt++;
         m_prev = sclk_o;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   function automatic int exp_half(input int pre, input int pow);
      return (pre + 1) << ((pow > 8) ? 8 : pow);
   endfunction

   function automatic logic [7:0] ctrl_byte(input bit en, input bit mstr, input int mode);
      return {1'b0, en, 1'b0, mstr, mode[1], mode[0], 2'b00};
   endfunction

   task automatic arm_model(input int mode, input logic [7:0] s);
      m_cpha = mode[0]; m_slv = s; m_cap = 8'h00;
      m_ecnt = 0; m_gap = 0; m_last = cyc; m_prev = sclk_o; m_on = 1'b1;
   endtask

   task automatic finish_master(input int mode, input int pre, input int pow,
                                input logic [7:0] d, input logic [7:0] s);
      logic [7:0] st, got;
      st = 8'h00;
      for (int k = 0; k < 20000 && !st[1]; k++) rd(2'd2, st);
      chk(st[1] == 1'b1, "R8 receive-full after frame", st, 8'h02);
      rd(2'd3, got);
      chk(got == s, "R6 master received byte", got, s);
      chk(m_cap == d, "R6 master sent byte MSB first", m_cap, d);
      chk(m_ecnt == 16, "R6 sixteen clock edges", m_ecnt, 16);
      chk(m_gap == exp_half(pre, pow), "R4 half period", m_gap, exp_half(pre, pow));
      chk(sclk_o == mode[1], "R11 clock parks at polarity", sclk_o, mode[1]);
      rd(2'd2, st);
      chk(st[1] == 1'b0, "R8 data read clears receive-full", st[1], 0);
      m_on = 1'b0;
   endtask

   task automatic master_xfer(input logic [7:0] d, input logic [7:0] s,
                              input int mode, input int pre, input int pow);
      logic [7:0] st;
      m_on = 1'b0;
      wr(2'd1, {1'b0, pre[2:0], pow[3:0]});
      wr(2'd0, ctrl_byte(1'b1, 1'b1, mode));
      arm_model(mode, s);
      wr(2'd3, d);
      rd(2'd2, st);
      chk(st[0] == 1'b1, "R7 byte moved into shifter", st[0], 1);
      finish_master(mode, pre, pow, d, s);
   endtask

   task automatic slave_xfer(input logic [7:0] mo, input logic [7:0] so, input int mode);
      localparam int H = 6;
      logic [7:0] st, got, cap;
      bit cpol;
      cpol = mode[1];
      cap = 8'h00;
      ss_n_i = 1'b1; sclk_i = cpol;
      wr(2'd0, ctrl_byte(1'b1, 1'b0, mode));
      repeat (4) @(negedge clk);
      wr(2'd3, so);
      rd(2'd2, st);
      chk(st[0] == 1'b1, "R7 slave byte loaded", st[0], 1);
      chk(miso_oe == 1'b0, "R9 output released with select high", miso_oe, 0);
      for (int k = 0; k < 6; k++) begin
         sclk_i = ~sclk_i;
         repeat (H) @(negedge clk);
      end
      rd(2'd2, st);
      chk(st[1] == 1'b0, "R9 edges ignored with select high", st[1], 0);
      if (!mode[0]) mosi_i = mo[7];
      ss_n_i = 1'b0;
      #1 chk(miso_oe == 1'b1, "R9 output driven with select low", miso_oe, 1);
      repeat (H) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         if (!mode[0]) begin
            cap = {cap[6:0], miso_o};
            sclk_i = ~cpol;
            repeat (H) @(negedge clk);
            sclk_i = cpol;
            if (i < 7) mosi_i = mo[6 - i];
            repeat (H) @(negedge clk);
         end else begin
            sclk_i = ~cpol;
            mosi_i = mo[7 - i];
            repeat (H) @(negedge clk);
            cap = {cap[6:0], miso_o};
            sclk_i = cpol;
            repeat (H) @(negedge clk);
         end
      end
      ss_n_i = 1'b1;
      repeat (H) @(negedge clk);
      rd(2'd2, st);
      chk(st[1] == 1'b1, "R10 slave receive-full", st[1], 1);
      rd(2'd3, got);
      chk(got == mo, "R10 slave received byte", got, mo);
      chk(cap == so, "R10 slave returned byte", cap, so);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=0x0 expected=0x1");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] v, a, b;
      int changes;
      void'($urandom(32'd7717));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      rd(2'd0, v); chk(v == 8'h00, "R1 control reset", v, 8'h00);
      rd(2'd1, v); chk(v == 8'h00, "R1 baud reset", v, 8'h00);
      rd(2'd2, v); chk(v == 8'h01, "R1 status reset", v, 8'h01);

      wr(2'd0, 8'hFF); rd(2'd0, v); chk(v == 8'h5C, "R2 control readback", v, 8'h5C);
      wr(2'd1, 8'hFF); rd(2'd1, v); chk(v == 8'h7F, "R2 baud readback", v, 8'h7F);
      wr(2'd0, 8'h00); wr(2'd1, 8'h00);

      // R3 and R7: byte held while disabled, second write ignored
      wr(2'd1, 8'h01);
      wr(2'd0, ctrl_byte(1'b0, 1'b1, 1));
      a = 8'hA6; b = 8'h3C;
      wr(2'd3, a);
      rd(2'd2, v); chk(v[0] == 1'b0, "R3 byte held while disabled", v[0], 0);
      wr(2'd3, b);
      changes = 0;
      v = {7'd0, sclk_o};
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         if (sclk_o !== v[0]) changes++;
         v[0] = sclk_o;
      end
      chk(changes == 0, "R3 no clock while disabled", changes, 0);
      rd(2'd2, v); chk(v[0] == 1'b0, "R3 transmit-empty stays low", v[0], 0);
      arm_model(1, 8'h5A);
      wr(2'd0, ctrl_byte(1'b1, 1'b1, 1));
      finish_master(1, 0, 1, a, 8'h5A);

      // directed modes and baud corners
      master_xfer(8'h81, 8'h7E, 0, 0, 0);
      master_xfer(8'hC3, 8'h18, 1, 7, 0);
      master_xfer(8'h0F, 8'hF0, 2, 0, 3);
      master_xfer(8'hE5, 8'h96, 3, 2, 2);
      master_xfer(8'h55, 8'hAA, 0, 0, 8);
      master_xfer(8'h1B, 8'hD4, 2, 0, 9);   // R5 saturation
      master_xfer(8'h72, 8'h2D, 1, 0, 15);  // R5 saturation

      // randomized master frames
      for (int n = 0; n < 12; n++) begin
         int unsigned r;
         r = $urandom();
         master_xfer(r[7:0], r[15:8], int'(r[17:16]), int'(r[20:19]), int'(r[23:22]));
      end

      // slave frames in every mode
      m_slv = 8'h00;
      for (int md = 0; md < 4; md++) begin
         int unsigned r;
         r = $urandom();
         slave_xfer(r[7:0], r[15:8], md);
      end
      slave_xfer(8'h80, 8'h01, 0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule